// File: doc/BRIEF.md
# Exposure Trigger Generator

This block drives the camera control line CC1 so that a camera exposes frames in step with the acquisition logic. A 3-bit exposure-mode code chooses how the line behaves. In the internal mode the camera sets its own timing, so CC1 stays low. In the two short-strobe modes, a brief pulse starts each frame and the pulse rate sets the frame rate. In one of these the camera uses its maximum exposure. In the other, the exposure comes from a separate command. In the width mode, the length of the high phase is itself the exposure time.

The host programs three clock-count values: the frame period, the exposure high time used by the width mode, and the strobe width used by the short-pulse modes. The block copies all settings into shadow registers only at the start of a period. A change made mid-frame therefore cannot cut a pulse short. A high time that does not fit inside the period is clipped, and an error flag is raised for that period. Clearing the enable lets the current period run to its end, and then the line stays low.

Top module: `expo_trig_gen`

## Requirements
- R1: While reset is asserted and after its release, `cc1` and `cfg_err` are 0 until a period is started.
- R2: Mode code 2 (camera-internal timing), and any code other than 3, 4 and 6, never starts a period, so `cc1` stays low.
- R3: In mode code 4, each period lasts `frame_period` cycles. `cc1` is high for the first `width_time` cycles of the period and low for the rest. A width of 0 gives no pulse.
- R4: In mode codes 3 and 6, each period lasts `frame_period` cycles, and `cc1` is high for the first `strobe_width` cycles of it.
- R5: When `enable` is 1 in a triggering mode and no period is running, a period starts at that clock edge. `cc1` is high in the cycle right after the edge (if the high time is nonzero).
- R6: If the selected high time is greater than or equal to the effective period, the high time becomes the period minus one. `cfg_err` is 1 for that period. The next period loaded with a fitting high time clears `cfg_err`.
- R7: A `frame_period` of 0 or 1 is treated as a period of 2 cycles.
- R8: Mode, period and high-time inputs are sampled only at the edge that starts a period. Changes in mid-period take effect at the next period start.
- R9: When `enable` is 0 at the end of a period, no new period starts, and a pulse in progress is never shortened. `cfg_err` keeps its last value while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts and continues trigger periods |
| exp_mode | input | 3 | Exposure mode code (2, 3, 4, 6) |
| frame_period | input | CNT_W | Period length in clock cycles |
| width_time | input | CNT_W | High time for mode 4 in clock cycles |
| strobe_width | input | CNT_W | Fixed pulse width for modes 3 and 6 |
| cc1 | output | 1 | Camera control line 1 trigger |
| cfg_err | output | 1 | High time was clipped for the current period |

## Verification
The bench changes the period, the high time and the mode in the middle of a frame. A design that applies them at once would produce a runt pulse or a stretched period. It sets a high time equal to or greater than the period. A wrong clip would hold CC1 high through the boundary or leave `cfg_err` stuck. It also uses periods of 0 and 1, a zero width, unlisted mode codes, and an enable that drops during a pulse. These catch a counter that wraps, a spurious pulse, or a truncated exposure.

// File: rtl/expo_trig_pkg.sv
`timescale 1ns/1ps
package expo_trig_pkg;
   typedef enum logic [2:0] {
      EXP_INTERNAL = 3'd2,
      EXP_MAXEXP   = 3'd3,
      EXP_WIDTH    = 3'd4,
      EXP_RATE     = 3'd6
   } expo_mode_e;

   function automatic logic mode_triggers(input logic [2:0] code);
      return (code == EXP_MAXEXP) || (code == EXP_WIDTH) || (code == EXP_RATE);
   endfunction

   function automatic logic mode_sets_width(input logic [2:0] code);
      return code == EXP_WIDTH;
   endfunction
endpackage

// File: rtl/expo_trig_cfg.sv
`timescale 1ns/1ps
module expo_trig_cfg
   import expo_trig_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             enable,
   input  logic [2:0]       exp_mode,
   input  logic [CNT_W-1:0] frame_period,
   input  logic [CNT_W-1:0] width_time,
   input  logic [CNT_W-1:0] strobe_width,
   output logic             ld_ok,
   output logic [CNT_W-1:0] ld_period,
   output logic [CNT_W-1:0] ld_high,
   output logic             ld_sat
);
   localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);
   logic [CNT_W-1:0] raw_high;

   // R7: floor the period at two cycles
   assign ld_period = (frame_period < MIN_PER) ? MIN_PER : frame_period;
   assign raw_high  = mode_sets_width(exp_mode) ? width_time : strobe_width;
   // R6: clip a high time that does not fit
   assign ld_sat    = raw_high >= ld_period;
   assign ld_high   = ld_sat ? (ld_period - CNT_W'(1)) : raw_high;
   assign ld_ok     = enable && mode_triggers(exp_mode);
endmodule

// File: rtl/expo_trig_seq.sv
`timescale 1ns/1ps
module expo_trig_seq #(
   parameter int unsigned CNT_W   = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_ok,
   input  logic [CNT_W-1:0] ld_period,
   input  logic [CNT_W-1:0] ld_high,
   input  logic             ld_sat,
   output logic             cc1,
   output logic             cfg_err
);
   logic             run_q, run_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, hi_q, hi_d;
   logic             err_q, err_d;
   logic             last_tick;

   assign last_tick = run_q && (cnt_q == per_q - CNT_W'(1));

   always_comb begin
      run_d = run_q;
      cnt_d = cnt_q;
      per_d = per_q;
      hi_d  = hi_q;
      err_d = err_q;
      if (!run_q || last_tick) begin
         cnt_d = '0;
         if (ld_ok) begin
            run_d = 1'b1;
            per_d = ld_period;
            hi_d  = ld_high;
            err_d = ld_sat;
         end else begin
            run_d = 1'b0;
         end
      end else begin
         cnt_d = cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         per_q <= CNT_W'(2);
         hi_q  <= '0;
         err_q <= 1'b0;
      end else begin
         run_q <= run_d;
         cnt_q <= cnt_d;
         per_q <= per_d;
         hi_q  <= hi_d;
         err_q <= err_d;
      end
   end

   assign cfg_err = err_q;

   generate
      if (REG_OUT) begin : g_reg_out
         logic cc1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cc1_q <= 1'b0;
            else        cc1_q <= run_d && (cnt_d < hi_d);
         end
         assign cc1 = cc1_q;
      end else begin : g_comb_out
         assign cc1 = run_q && (cnt_q < hi_q);
      end
   endgenerate

   // R5
   pulse_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cc1) |-> (cnt_q == '0));
   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cc1) |-> (cnt_q == $past(hi_q)));
   // R6
   high_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (hi_q < per_q));
   // R7
   min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (per_q >= CNT_W'(2)));
   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q != '0) |-> ($stable(per_q) && $stable(hi_q) && $stable(err_q)));
   // R9
   stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(cnt_q) == $past(per_q) - CNT_W'(1)));
endmodule

// File: rtl/expo_trig_gen.sv
`timescale 1ns/1ps
module expo_trig_gen #(
   parameter int unsigned CNT_W   = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [2:0]       exp_mode,
   input  logic [CNT_W-1:0] frame_period,
   input  logic [CNT_W-1:0] width_time,
   input  logic [CNT_W-1:0] strobe_width,
   output logic             cc1,
   output logic             cfg_err
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("expo_trig_gen: CNT_W must lie in 2..64");
      end
   endgenerate

   logic             ld_ok, ld_sat;
   logic [CNT_W-1:0] ld_period, ld_high;

   expo_trig_cfg #(.CNT_W(CNT_W)) u_cfg (
      .enable       (enable),
      .exp_mode     (exp_mode),
      .frame_period (frame_period),
      .width_time   (width_time),
      .strobe_width (strobe_width),
      .ld_ok        (ld_ok),
      .ld_period    (ld_period),
      .ld_high      (ld_high),
      .ld_sat       (ld_sat)
   );

   expo_trig_seq #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_ok     (ld_ok),
      .ld_period (ld_period),
      .ld_high   (ld_high),
      .ld_sat    (ld_sat),
      .cc1       (cc1),
      .cfg_err   (cfg_err)
   );

   // R2
   quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cc1 && !ld_ok) |=> !$rose(cc1));
endmodule

// File: tb/test_expo_trig_gen.sv
`timescale 1ns/1ps
module test_expo_trig_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [2:0]  exp_mode = 3'd2;
   logic [31:0] frame_period = 32'd4;
   logic [31:0] width_time = 32'd1;
   logic [31:0] strobe_width = 32'd1;
   logic        cc1, cfg_err;

   int    checks = 0;
   int    fails = 0;
   string tag = "R1";
   bit    done = 1'b0;

   always #2 clk = ~clk;

   expo_trig_gen #(.CNT_W(32)) i_expo_trig_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .exp_mode(exp_mode),
      .frame_period(frame_period), .width_time(width_time),
      .strobe_width(strobe_width), .cc1(cc1), .cfg_err(cfg_err));

   function automatic bit triggers(input logic [2:0] m);
      return (m == 3'd3) || (m == 3'd4) || (m == 3'd6);
   endfunction
   function automatic logic [31:0] eff_period(input logic [31:0] p);
      return (p < 32'd2) ? 32'd2 : p;
   endfunction
   function automatic logic [31:0] want_high(input logic [2:0] m, input logic [31:0] w,
                                             input logic [31:0] s);
      return (m == 3'd4) ? w : s;
   endfunction

   // reference model built from the requirements
   bit          m_run = 1'b0;
   logic [31:0] m_cnt = '0, m_per = 32'd2, m_hi = '0;
   bit          m_err = 1'b0;

   always @(posedge clk) begin
      logic [31:0] h;
      if (!rst_n) begin
         m_run = 1'b0; m_cnt = '0; m_per = 32'd2; m_hi = '0; m_err = 1'b0;
      end else if (!m_run || m_cnt == m_per - 32'd1) begin
         m_cnt = '0;
         if (enable && triggers(exp_mode)) begin
            m_run = 1'b1;
            m_per = eff_period(frame_period);
            h = want_high(exp_mode, width_time, strobe_width);
            if (h >= m_per) begin m_hi = m_per - 32'd1; m_err = 1'b1; end
            else begin m_hi = h; m_err = 1'b0; end
         end else begin
            m_run = 1'b0;
         end
      end else begin
         m_cnt = m_cnt + 32'd1;
      end
   end

   always @(negedge clk) begin
      bit exp_cc1;
      if (rst_n && !done) begin
         exp_cc1 = m_run && (m_cnt < m_hi);
         checks++;
         if (cc1 !== exp_cc1 || cfg_err !== m_err) begin
            fails++;
            $display("FAIL %s cc1=%0b expected=%0b cfg_err=%0b expected=%0b t=%0t",
                     tag, cc1, exp_cc1, cfg_err, m_err, $time);
         end
      end
   end

   task automatic seg(input string t, input bit en, input logic [2:0] m,
                      input logic [31:0] p, input logic [31:0] w,
                      input logic [31:0] s, input int n);
      @(negedge clk);
      tag = t; enable = en; exp_mode = m;
      frame_period = p; width_time = w; strobe_width = s;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      checks++;
      if (cc1 !== 1'b0 || cfg_err !== 1'b0) begin
         fails++;
         $display("FAIL R1 cc1=%0b cfg_err=%0b expected=0 0", cc1, cfg_err);
      end
      rst_n = 1'b1;
      seg("R1", 1'b0, 3'd4, 32'd5, 32'd2, 32'd1, 4);
      // R2: internal mode and unlisted codes stay quiet
      seg("R2", 1'b1, 3'd2, 32'd5, 32'd2, 32'd1, 12);
      seg("R2", 1'b1, 3'd5, 32'd5, 32'd2, 32'd1, 12);
      seg("R2", 1'b1, 3'd0, 32'd5, 32'd2, 32'd1, 12);
      // R3 / R5: width mode, including zero width
      seg("R5", 1'b1, 3'd4, 32'd6, 32'd2, 32'd1, 20);
      seg("R3", 1'b1, 3'd4, 32'd6, 32'd0, 32'd1, 14);
      seg("R3", 1'b1, 3'd4, 32'd7, 32'd5, 32'd1, 21);
      // R4: strobe modes
      seg("R4", 1'b1, 3'd3, 32'd8, 32'd6, 32'd3, 24);
      seg("R4", 1'b1, 3'd6, 32'd4, 32'd6, 32'd1, 16);
      // R6: clipping and clearing of the error flag
      seg("R6", 1'b1, 3'd4, 32'd5, 32'd9, 32'd1, 15);
      seg("R6", 1'b1, 3'd4, 32'd5, 32'd5, 32'd1, 10);
      seg("R6", 1'b1, 3'd4, 32'd5, 32'd2, 32'd1, 12);
      // R7: tiny periods
      seg("R7", 1'b1, 3'd4, 32'd0, 32'd1, 32'd1, 8);
      seg("R7", 1'b1, 3'd3, 32'd1, 32'd1, 32'd4, 8);
      // R8: mid-period change
      seg("R8", 1'b1, 3'd4, 32'd10, 32'd3, 32'd1, 13);
      seg("R8", 1'b1, 3'd6, 32'd4, 32'd3, 32'd2, 14);
      // R9: enable dropped during a pulse
      seg("R9", 1'b1, 3'd4, 32'd8, 32'd5, 32'd1, 10);
      seg("R9", 1'b0, 3'd4, 32'd8, 32'd5, 32'd1, 16);
      seg("R9", 1'b1, 3'd3, 32'd6, 32'd1, 32'd9, 8);
      seg("R9", 1'b0, 3'd3, 32'd6, 32'd1, 32'd9, 10);
      // R8: constrained random segments
      for (int i = 0; i < 120; i++) begin
         logic [2:0] m;
         case ($urandom_range(0, 5))
            0: m = 3'd2;
            1: m = 3'd3;
            2: m = 3'd4;
            3: m = 3'd6;
            4: m = 3'd4;
            default: m = 3'($urandom_range(0, 7));
         endcase
         seg("R8", ($urandom_range(0, 9) != 0), m,
             32'($urandom_range(0, 12)), 32'($urandom_range(0, 14)),
             32'($urandom_range(0, 5)), $urandom_range(1, 30));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule